// File: doc/BRIEF.md
# Multiplexed Fluorescent Display Grid Scanner with Stepped Dimmer

This block produces the time-multiplexed drive pattern for a vacuum fluorescent display. It walks through one grid slot per digit, 4 to 11 digits per frame as chosen by a 3-bit layout code. Each grid slot is cut into 16 equal sections, and each section is one pulse of `tick_en`. During the lit part of a slot, the grid line of the current digit is driven high together with up to 16 segment lines. The segment lines come from a 16-bit word read from display memory. A 3-bit brightness code sets how many of the 16 sections are lit, on a non-linear scale.

There are 16 segment-capable pins. The highest five of them are shared. When the layout asks for more than six digits, these shared pins take over as grid lines, beginning at the top pin and working downward, and the number of segments shrinks by one for each pin taken. A one-cycle frame-end pulse marks the point where the last slot of a frame wraps back to digit 0; the key-scan latch uses it. A change to the layout or brightness code is adopted only at a slot boundary, so no slot is ever cut short. The display-enable input blanks all outputs at once and leaves the timing running.

Top module: `vfd_grid_mux`

## Requirements
- R1: After reset the section and digit counters are 0 and `mem_addr_o` is 0. The adopted layout is code 111 and the adopted brightness is code 000. `frame_end_o` is low.
- R2: Each cycle with `tick_en` high advances the section count by one. After 16 sections the digit advances, and `mem_addr_o` always equals twice the current digit.
- R3: Outputs are lit only in sections 0 to W-1 of a slot. W is 1, 2, 4, 10, 11, 12, 13 or 14 for brightness codes 000 through 111.
- R4: Layout code m (0..7) gives 4+m digits per frame. The digit counter wraps from the last digit of the frame back to 0.
- R5: `mem_data_i` carries the byte at address 2k in bits 7:0 and the byte at 2k+1 in bits 15:8. A lit segment pin p shows bit p of this word.
- R6: The segment count is 16 for layout codes 0 to 2 and 18-m for m of 3 or more. A pin p at or above the segment count acts as the grid for digit 21-p and never shows memory data.
- R7: While `disp_on_i` is low, all of `grid_o` and `seg_pin_o` are 0 in the same cycle. Counting continues.
- R8: `frame_end_o` is high for exactly one cycle, the cycle that follows the tick ending the last slot of a frame.
- R9: The layout and brightness inputs are sampled only on the tick that ends a slot. The slot in progress keeps the previous values.
- R10: Among the grid lines (`grid_o` plus the shared pins acting as grids), at most one is high, and it belongs to the current digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Section enable; 16 pulses make one grid slot |
| mode_i | input | 3 | Layout code: digit/segment split |
| dim_i | input | 3 | Brightness code |
| disp_on_i | input | 1 | Display enable |
| mem_addr_o | output | 5 | Even byte address of the current digit |
| mem_data_i | input | 16 | Word {byte 2k+1, byte 2k} for the current digit |
| grid_o | output | 6 | Dedicated grid lines for digits 0 to 5 |
| seg_pin_o | output | 16 | Segment pins; pins 11 to 15 may act as grids |
| frame_end_o | output | 1 | One-cycle pulse at frame wrap |

## Verification
A table pairs each of the eight layout codes with a different brightness code, and every section of every slot in one full frame is compared. This separates a wrong lit width from a wrong digit count, wrong shared-pin roles, and wrong byte order, because a different memory pattern is loaded for each row. Directed cases cover the reset state and blanking while the timing keeps running. They also change the brightness and layout codes in the middle of a slot, where a design that adopts the codes early would light a dark section or turn a grid pin into a segment too soon.

// File: rtl/vfd_mux_pkg.sv
package vfd_mux_pkg;
  localparam int SECT_W    = 4;
  localparam int NUM_SECT  = 1 << SECT_W;
  localparam int DIG_W     = 4;
  localparam int MIN_DIGITS = 4;
  localparam int PIN_CNT   = 16;
  localparam int DED_GRIDS = 6;
  localparam int CODE_W    = 3;
  localparam int ADDR_W    = DIG_W + 1;
  localparam int WIDTH_W   = SECT_W + 1;
  localparam int PINSEL_W  = $clog2(PIN_CNT) + 1;

  // lit sections per brightness code (non-linear scale)
  function automatic logic [WIDTH_W-1:0] on_width(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    on_width = WIDTH_W'(1);
      3'd1:    on_width = WIDTH_W'(2);
      3'd2:    on_width = WIDTH_W'(4);
      3'd3:    on_width = WIDTH_W'(10);
      3'd4:    on_width = WIDTH_W'(11);
      3'd5:    on_width = WIDTH_W'(12);
      3'd6:    on_width = WIDTH_W'(13);
      default: on_width = WIDTH_W'(14);
    endcase
  endfunction

  function automatic logic [DIG_W-1:0] digit_count(input logic [CODE_W-1:0] m);
    digit_count = DIG_W'(m) + DIG_W'(MIN_DIGITS);
  endfunction

  function automatic logic [PINSEL_W-1:0] seg_count(input logic [CODE_W-1:0] m);
    if (m <= 3'd2) seg_count = PINSEL_W'(PIN_CNT);
    else           seg_count = PINSEL_W'(PIN_CNT + 2) - PINSEL_W'(m);
  endfunction
endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer
  import vfd_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] mode_i,
  input  logic [CODE_W-1:0] dim_i,
  output logic [SECT_W-1:0] sect_o,
  output logic [DIG_W-1:0]  digit_o,
  output logic [CODE_W-1:0] mode_o,
  output logic [CODE_W-1:0] dim_o,
  output logic              frame_end_o
);
  logic [SECT_W-1:0] sect_q, sect_d;
  logic [DIG_W-1:0]  digit_q, digit_d, dig_inc;
  logic [CODE_W-1:0] mode_q, mode_d, dim_q, dim_d;
  logic              fe_q, fe_d;
  logic              slot_end, wrap;

  always_comb begin
    slot_end = tick_en && (sect_q == {SECT_W{1'b1}});
    dig_inc  = digit_q + DIG_W'(1);
    wrap     = slot_end && (dig_inc >= digit_count(mode_i));
    sect_d   = tick_en ? sect_q + SECT_W'(1) : sect_q;
    digit_d  = digit_q;
    mode_d   = mode_q;
    dim_d    = dim_q;
    if (slot_end) begin
      digit_d = wrap ? '0 : dig_inc;
      mode_d  = mode_i;
      dim_d   = dim_i;
    end
    fe_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_q  <= '0;
      digit_q <= '0;
      mode_q  <= {CODE_W{1'b1}};
      dim_q   <= '0;
      fe_q    <= 1'b0;
    end else begin
      sect_q  <= sect_d;
      digit_q <= digit_d;
      mode_q  <= mode_d;
      dim_q   <= dim_d;
      fe_q    <= fe_d;
    end
  end

  assign sect_o      = sect_q;
  assign digit_o     = digit_q;
  assign mode_o      = mode_q;
  assign dim_o       = dim_q;
  assign frame_end_o = fe_q;

  AST_DIGIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    digit_q < digit_count(mode_q)); // R4
  AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> ($stable(mode_q) && $stable(dim_q))); // R9
  AST_FRAME_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    fe_q |=> !fe_q); // R8
  AST_FRAME_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    fe_q |-> (digit_q == '0 && sect_q == '0)); // R8
endmodule

// File: rtl/vfd_pwm_gate.sv
module vfd_pwm_gate
  import vfd_mux_pkg::*;
(
  input  logic [SECT_W-1:0] sect_i,
  input  logic [CODE_W-1:0] dim_i,
  input  logic              disp_on_i,
  output logic              lit_o
);
  always_comb begin
    lit_o = disp_on_i && ({1'b0, sect_i} < on_width(dim_i));
  end
endmodule

// File: rtl/vfd_pin_mapper.sv
module vfd_pin_mapper
  import vfd_mux_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lit_i,
  input  logic [DIG_W-1:0]   digit_i,
  input  logic [CODE_W-1:0]  mode_i,
  input  logic [PIN_CNT-1:0] word_i,
  output logic [PIN_CNT-1:0] seg_pin_o,
  output logic [DED_GRIDS-1:0] grid_o
);
  logic [PIN_CNT-1:0]  grid_role;
  logic [PINSEL_W-1:0] nseg;

  assign nseg = seg_count(mode_i);

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    localparam int GRID_ID = DED_GRIDS + PIN_CNT - 1 - p;
    always_comb begin
      grid_role[p] = (PINSEL_W'(p) >= nseg);
      if (grid_role[p]) seg_pin_o[p] = lit_i && (int'(digit_i) == GRID_ID);
      else              seg_pin_o[p] = lit_i && word_i[p];
    end
  end

  for (genvar g = 0; g < DED_GRIDS; g++) begin : g_grid
    assign grid_o[g] = lit_i && (int'(digit_i) == g);
  end

  AST_SINGLE_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grid_o, seg_pin_o & grid_role})); // R10
endmodule

// File: rtl/vfd_grid_mux.sv
module vfd_grid_mux
  import vfd_mux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [CODE_W-1:0]    mode_i,
  input  logic [CODE_W-1:0]    dim_i,
  input  logic                 disp_on_i,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic [PIN_CNT-1:0]   mem_data_i,
  output logic [DED_GRIDS-1:0] grid_o,
  output logic [PIN_CNT-1:0]   seg_pin_o,
  output logic                 frame_end_o
);
  logic [SECT_W-1:0] sect;
  logic [DIG_W-1:0]  digit;
  logic [CODE_W-1:0] mode_q, dim_q;
  logic              lit;

  vfd_slot_timer u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .mode_i      (mode_i),
    .dim_i       (dim_i),
    .sect_o      (sect),
    .digit_o     (digit),
    .mode_o      (mode_q),
    .dim_o       (dim_q),
    .frame_end_o (frame_end_o)
  );

  vfd_pwm_gate u_pwm (
    .sect_i    (sect),
    .dim_i     (dim_q),
    .disp_on_i (disp_on_i),
    .lit_o     (lit)
  );

  vfd_pin_mapper u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .lit_i     (lit),
    .digit_i   (digit),
    .mode_i    (mode_q),
    .word_i    (mem_data_i),
    .seg_pin_o (seg_pin_o),
    .grid_o    (grid_o)
  );

  assign mem_addr_o = {digit, 1'b0};

  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on_i |-> (grid_o == '0 && seg_pin_o == '0)); // R7
  AST_EVEN_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_addr_o[0]); // R2
endmodule

// File: tb/vfd_grid_mux_tb.sv
`timescale 1ns/1ps
module vfd_grid_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [2:0]  dim_i = 3'd0;
  logic        disp_on_i = 1'b0;
  logic [4:0]  mem_addr_o;
  logic [15:0] mem_data_i;
  logic [5:0]  grid_o;
  logic [15:0] seg_pin_o;
  logic        frame_end_o;
  logic [7:0]  mem [0:21];
  int          n_chk = 0;
  int          n_bad = 0;
  logic        fe_seen;

  always #10 clk = ~clk;

  always_comb begin
    int a;
    a = int'(mem_addr_o);
    mem_data_i = (a <= 20) ? {mem[a+1], mem[a]} : 16'h0;
  end

  vfd_grid_mux u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_i(mode_i), .dim_i(dim_i),
    .disp_on_i(disp_on_i), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .grid_o(grid_o), .seg_pin_o(seg_pin_o), .frame_end_o(frame_end_o)
  );

  // {mode, dim, lit width, digits, segments} derived from R3, R4, R6
  localparam logic [19:0] ROWS [0:7] = '{
    {3'd0, 3'd7, 5'd14, 4'd4,  5'd16},
    {3'd1, 3'd6, 5'd13, 4'd5,  5'd16},
    {3'd2, 3'd5, 5'd12, 4'd6,  5'd16},
    {3'd3, 3'd4, 5'd11, 4'd7,  5'd15},
    {3'd4, 3'd3, 5'd10, 4'd8,  5'd14},
    {3'd5, 3'd2, 5'd4,  4'd9,  5'd13},
    {3'd6, 3'd1, 5'd2,  4'd10, 5'd12},
    {3'd7, 3'd0, 5'd1,  4'd11, 5'd11}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    fe_seen = frame_end_o;
  endtask

  task automatic align_frame();
    for (int i = 0; i < 400; i++) begin
      tick();
      if (fe_seen) break;
    end
  endtask

  // expected pins from requirements R3 R5 R6 R10
  task automatic check_slot(input int d, input int s, input int w, input int nseg, input bit on);
    logic [15:0] word, exp_seg;
    logic [5:0]  exp_grid;
    bit          lit;
    lit  = on && (s < w);
    word = {mem[2*d+1], mem[2*d]};
    for (int p = 0; p < 16; p++)
      exp_seg[p] = (p < nseg) ? (lit && word[p]) : (lit && (d == 21 - p));
    for (int g = 0; g < 6; g++) exp_grid[g] = lit && (d == g);
    check(seg_pin_o == exp_seg && grid_o == exp_grid, "R3 R5 R6 R10 pins",
          {grid_o, seg_pin_o}, {exp_grid, exp_seg});
    check(mem_addr_o == 5'(2*d), "R2 address", 32'(mem_addr_o), 32'(2*d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 22; i++) mem[i] = 8'(i * 13 + 7);
    mode_i = 3'd0; dim_i = 3'd3; disp_on_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, layout 111 and brightness 000 adopted
    check(frame_end_o == 1'b0, "R1 frame_end", 32'(frame_end_o), 0);
    check_slot(0, 0, 1, 11, 1'b1);
    tick();
    check_slot(0, 1, 1, 11, 1'b1); // R1: width 1, so section 1 is dark

    // R7: blank while counting goes on
    disp_on_i = 1'b0;
    @(negedge clk);
    check(grid_o == 0 && seg_pin_o == 0, "R7 blank", {grid_o, seg_pin_o}, 0);
    for (int i = 0; i < 15; i++) tick();
    check(grid_o == 0 && seg_pin_o == 0, "R7 blank after ticks", {grid_o, seg_pin_o}, 0);
    disp_on_i = 1'b1;
    @(negedge clk);
    check_slot(1, 0, 10, 16, 1'b1); // R7 counting continued, R9 new codes adopted

    // table walk: R2 R3 R4 R5 R6 R8
    for (int r = 0; r < 8; r++) begin
      logic [19:0] row;
      int w, nd, ns;
      row = ROWS[r];
      mode_i = row[19:17]; dim_i = row[16:14];
      w = int'(row[13:9]); nd = int'(row[8:5]); ns = int'(row[4:0]);
      for (int i = 0; i < 22; i++) mem[i] = 8'(i * 29 + r * 71 + 5);
      align_frame();
      check(fe_seen == 1'b1, "R8 frame_end at alignment", 32'(fe_seen), 1);
      for (int d = 0; d < nd; d++)
        for (int s = 0; s < 16; s++) begin
          check_slot(d, s, w, ns, 1'b1);
          tick();
          check(fe_seen == (d == nd - 1 && s == 15), "R4 R8 frame_end timing",
                32'(fe_seen), 32'(d == nd - 1 && s == 15));
        end
      @(negedge clk);
      check(frame_end_o == 1'b0, "R8 one-cycle pulse", 32'(frame_end_o), 0);
    end

    // R9: brightness and layout change mid-slot
    for (int i = 0; i < 22; i++) mem[i] = 8'hFF;
    mode_i = 3'd7; dim_i = 3'd0;
    align_frame();
    for (int i = 0; i < 3; i++) tick();
    dim_i = 3'd7;
    @(negedge clk);
    check_slot(0, 3, 1, 11, 1'b1); // R9: old width still applies
    for (int i = 0; i < 16; i++) tick();
    check_slot(1, 3, 14, 11, 1'b1); // R9: new width after boundary
    mode_i = 3'd0;
    @(negedge clk);
    check(seg_pin_o[15] == 1'b0, "R9 pin 15 still a grid", 32'(seg_pin_o[15]), 0);
    for (int i = 0; i < 13; i++) tick();
    check_slot(2, 0, 14, 16, 1'b1); // R6 R9: pin 15 now a segment
    check(seg_pin_o[15] == 1'b1, "R9 pin 15 as segment", 32'(seg_pin_o[15]), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule